// File: doc/BRIEF.md
# Half-Pixel Character Row Serializer

This block produces one scan line of a text character cell as a serial dot stream. A character is offered on a valid/ready input together with the scan line inside the cell and three display controls: blanking, a cursor/light-pen highlight, and reverse video. The block forms the font address from the code and the low bits of the scan line. It takes the font byte that returns one dot clock later and expands it into a 14-dot pattern. It then shifts the pattern out, most significant dot first, one dot per clock.

The expansion doubles each of the six upper font bits into a pair of adjacent dots. The two lowest font bits do not draw anything. Each one decides whether its part of the glyph is pushed one dot to the right: bit 1 controls the left part and bit 0 the right part. This gives half-dot smoothing of diagonal strokes.

The cell timer runs freely with a 14-dot period. The input accepts at most one character per cell and only in a single slot. Back-pressure rules: `in_ready` is high in exactly one cycle per cell. A character is taken only in a cycle where `in_valid` and `in_ready` are both high. A source that is not ready in that slot gets a blank cell. The dot output has no back-pressure, because the display cannot stall.

Top module: `hp_row_serializer`

## Requirements
- R1: `in_ready` is high for exactly one cycle in every 14 and low otherwise. The first high cycle is the 12th cycle after reset is released (cell dot index 11). A character is accepted only when `in_valid` and `in_ready` are both high.
- R2: The cycle after acceptance, `font_addr` equals code × 8 + scan line bits [2:0]. It holds that value until the next acceptance.
- R3: `font_data` is taken two cycles after acceptance, which is one cycle after the address. The 14 dots then appear on `pix_out` with `pix_valid` high in the 14 cycles that follow, starting with pattern bit 13.
- R4: Font bits 7..2 each drive a pair of dots: bit k drives pattern positions 2k-1 and 2k-2.
- R5: When font bit 1 is 0, pattern positions 13..6 are taken one position higher in the doubled word (a one-dot right delay; position 13 becomes 0). When bit 1 is 1, they are taken undelayed.
- R6: Font bit 0 does the same for positions 5..1. Position 0 is always 0 for a drawn glyph.
- R7: With the cursor control set, all 14 dots are on, whatever the blanking controls say.
- R8: With blanking set, or scan line bit 3 set, all dots are off unless the cursor is set. Scan line bits above bit 3 have no effect.
- R9: With reverse video set, all 14 dots of the result of R4–R8 are inverted, including the cursor and blank cases.
- R10: A cell for which no character was accepted has `pix_valid` low and `pix_out` low for all 14 cycles.
- R11: While reset is held, `in_ready`, `pix_valid` and `pix_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character slot open this cycle |
| in_code | input | CODE_W | Character code |
| in_line | input | LINE_W | Scan line inside the cell |
| in_suppress | input | 1 | Blank this cell |
| in_cursor | input | 1 | Light all 14 dots |
| in_reverse | input | 1 | Invert the dot pattern |
| font_addr | output | CODE_W+3 | Font memory address |
| font_data | input | 8 | Font byte, valid one cycle after the address |
| pix_out | output | 1 | Serial dot |
| pix_valid | output | 1 | Dot belongs to an accepted character |

## Verification
The bench builds the block with an 8-bit code and a 5-bit scan line. The wider line makes it possible to check that bit 4 of the line leaves the glyph alone while bit 3 blanks it. The bench's font memory returns a value derived from the address in a way that any address error changes the expected dots. Chosen codes reach the four combinations of the two delay bits, all-ones and all-zeros glyphs, and the cursor, blank and reverse interactions.

// File: rtl/hp_row_pkg.sv
package hp_row_pkg;
  localparam int CELL_W = 14;
  localparam int FONT_W = 8;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] LEFT_MASK  = 16'h3FC0;
  localparam logic [WORD_W-1:0] RIGHT_MASK = 16'h003E;

  typedef struct packed {
    logic cursor;
    logic blank;
    logic invert;
  } cell_attr_t;
endpackage

// File: rtl/hp_dot_timer.sv
module hp_dot_timer #(
  parameter int CELL = 14
) (
  input  logic clk,
  input  logic rst_n,
  output logic accept_slot,
  output logic load_slot
);
  localparam int CNT_W = $clog2(CELL);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == CNT_W'(CELL-1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign accept_slot = rst_n && (cnt == CNT_W'(CELL-3));
  assign load_slot   = (cnt == CNT_W'(CELL-1));
endmodule

// File: rtl/hp_glyph_expand.sv
module hp_glyph_expand
  import hp_row_pkg::*;
(
  input  logic [FONT_W-1:0] font,
  input  cell_attr_t        attr,
  output logic [CELL_W-1:0] pattern
);
  logic [WORD_W-1:0] dbl;
  logic [WORD_W-1:0] left_part;
  logic [WORD_W-1:0] right_part;
  logic [CELL_W-1:0] glyph;
  logic [CELL_W-1:0] shaped;

  assign dbl[1:0] = 2'b00;
  assign dbl[WORD_W-1:WORD_W-2] = 2'b00;
  for (genvar k = 2; k < FONT_W; k++) begin : g_double
    assign dbl[2*k-1] = font[k];
    assign dbl[2*k-2] = font[k];
  end

  always_comb begin
    left_part  = (font[1] ? dbl : (dbl >> 1)) & LEFT_MASK;
    right_part = (font[0] ? dbl : (dbl >> 1)) & RIGHT_MASK;
    glyph      = CELL_W'(left_part | right_part);
    if (attr.cursor)     shaped = '1;
    else if (attr.blank) shaped = '0;
    else                 shaped = glyph;
    pattern = attr.invert ? ~shaped : shaped;
  end
endmodule

// File: rtl/hp_row_shifter.sv
module hp_row_shifter #(
  parameter int CELL = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            load_valid,
  input  logic [CELL-1:0] pattern,
  output logic            dot,
  output logic            dot_valid
);
  logic [CELL-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      dot_valid <= 1'b0;
    end else if (load) begin
      sh        <= load_valid ? pattern : '0;
      dot_valid <= load_valid;
    end else begin
      sh        <= {sh[CELL-2:0], 1'b0};
    end
  end

  assign dot = sh[CELL-1];
endmodule

// File: rtl/hp_row_serializer.sv
module hp_row_serializer
  import hp_row_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LINE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CODE_W-1:0]   in_code,
  input  logic [LINE_W-1:0]   in_line,
  input  logic                in_suppress,
  input  logic                in_cursor,
  input  logic                in_reverse,
  output logic [CODE_W+2:0]   font_addr,
  input  logic [FONT_W-1:0]   font_data,
  output logic                pix_out,
  output logic                pix_valid
);
  localparam int ADDR_W = CODE_W + 3;

  logic       accept_slot;
  logic       load_slot;
  logic       take;
  logic       pending;
  cell_attr_t attr_q;
  logic [CELL_W-1:0] pattern;

  hp_dot_timer #(.CELL(CELL_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_slot (accept_slot),
    .load_slot   (load_slot)
  );

  assign in_ready = accept_slot;
  assign take     = in_valid && accept_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      font_addr <= '0;
      attr_q    <= '0;
      pending   <= 1'b0;
    end else if (take) begin
      font_addr     <= ADDR_W'({in_code, in_line[2:0]});
      attr_q.cursor <= in_cursor;
      attr_q.blank  <= in_suppress | in_line[3];
      attr_q.invert <= in_reverse;
      pending       <= 1'b1;
    end else if (load_slot) begin
      pending <= 1'b0;
    end
  end

  hp_glyph_expand u_expand (
    .font    (font_data),
    .attr    (attr_q),
    .pattern (pattern)
  );

  hp_row_shifter #(.CELL(CELL_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_slot),
    .load_valid (pending),
    .pattern    (pattern),
    .dot        (pix_out),
    .dot_valid  (pix_valid)
  );
endmodule

// File: rtl/hp_row_serializer_chk.sv
module hp_row_serializer_chk #(
  parameter int CODE_W = 8,
  parameter int LINE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CODE_W-1:0] in_code,
  input logic [LINE_W-1:0] in_line,
  input logic [CODE_W+2:0] font_addr,
  input logic              pix_out,
  input logic              pix_valid
);
  a_r1_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  a_r2_addr_formed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> font_addr == {$past(in_code), $past(in_line[2:0])});

  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(font_addr));

  a_r3_start_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> $past(in_valid && in_ready, 3));

  a_r10_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> !pix_out);
endmodule

bind hp_row_serializer hp_row_serializer_chk #(.CODE_W(CODE_W), .LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_code   (in_code),
  .in_line   (in_line),
  .font_addr (font_addr),
  .pix_out   (pix_out),
  .pix_valid (pix_valid)
);

// File: tb/sim_hp_row_serializer.sv
`timescale 1ns/1ps
module sim_hp_row_serializer;
  localparam int CODE_W = 8;
  localparam int LINE_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [CODE_W-1:0] in_code = '0;
  logic [LINE_W-1:0] in_line = '0;
  logic in_suppress = 1'b0, in_cursor = 1'b0, in_reverse = 1'b0;
  logic [CODE_W+2:0] font_addr;
  logic [7:0] font_data = '0;
  logic pix_out, pix_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  hp_row_serializer #(.CODE_W(CODE_W), .LINE_W(LINE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_line(in_line), .in_suppress(in_suppress),
    .in_cursor(in_cursor), .in_reverse(in_reverse), .font_addr(font_addr),
    .font_data(font_data), .pix_out(pix_out), .pix_valid(pix_valid)
  );

  function automatic logic [7:0] font_of(input logic [CODE_W+2:0] a);
    return a[CODE_W+2:3] ^ {a[2:0], 5'b0};
  endfunction

  // font memory model: data one cycle after the address
  always @(posedge clk) font_data <= font_of(font_addr);

  function automatic logic [13:0] exp_row(input logic [7:0] f, input logic cur,
                                          input logic blank, input logic rev);
    logic [13:0] r;
    for (int d = 0; d < 14; d++) begin
      int src;
      if (d >= 6)      src = f[1] ? d : d + 1;
      else if (d >= 1) src = f[0] ? d : d + 1;
      else             src = -1;
      r[d] = (src >= 2 && src <= 13) ? f[src/2 + 1] : 1'b0;
    end
    if (cur) r = '1;
    else if (blank) r = '0;
    if (rev) r = ~r;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_char(input string req, input logic [CODE_W-1:0] code,
                           input logic [LINE_W-1:0] line, input logic sup,
                           input logic cur, input logic rev);
    logic [CODE_W+2:0] ea;
    logic [13:0] got, exp;
    int vcount;
    ea = {code, line[2:0]};
    exp = exp_row(font_of(ea), cur, sup | line[3], rev);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_code = code; in_line = line;
    in_suppress = sup; in_cursor = cur; in_reverse = rev;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(font_addr == ea, "R2 address", 32'(font_addr), 32'(ea));
    @(posedge clk);
    @(posedge clk);
    vcount = 0;
    for (int i = 13; i >= 0; i--) begin
      @(negedge clk);
      got[i] = pix_out;
      if (pix_valid) vcount++;
    end
    check(vcount == 14, "R3 valid run", 32'(vcount), 32'd14);
    check(got == exp, req, 32'(got), 32'(exp));
  endtask

  task automatic t_reset;
    check(!in_ready && !pix_valid && !pix_out, "R11 reset state",
          {29'd0, in_ready, pix_valid, pix_out}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    begin
      int k = 0;
      @(negedge clk);
      while (!in_ready && k < 40) begin k++; @(negedge clk); end
      check(k == 11, "R1 first slot", 32'(k), 32'd11);
    end
  endtask

  task automatic t_ready_period;
    int n = 0;
    for (int i = 0; i < 56; i++) begin
      @(negedge clk);
      if (in_ready) n++;
    end
    check(n == 4, "R1 one slot per cell", 32'(n), 32'd4);
  endtask

  task automatic t_idle;
    int bad = 0;
    // the cell after a lone character carries nothing
    @(posedge clk);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (pix_valid || pix_out) bad++;
    end
    check(bad == 0, "R10 empty cell", 32'(bad), 32'd0);
  endtask

  initial begin
    t_reset();
    t_ready_period();
    send_char("R4 all bits",        8'hFF, 5'd0,  0, 0, 0);
    send_char("R5 R6 both delayed", 8'hFC, 5'd0,  0, 0, 0);
    send_char("R5 left delayed",    8'hA5, 5'd0,  0, 0, 0);
    send_char("R6 right delayed",   8'h5A, 5'd0,  0, 0, 0);
    send_char("R4 other line",      8'h3C, 5'd5,  0, 0, 0);
    t_idle();
    send_char("R7 cursor over blank", 8'h00, 5'd8, 1, 1, 0);
    send_char("R8 suppress",        8'hFF, 5'd2,  1, 0, 0);
    send_char("R8 line bit3",       8'hFF, 5'd9,  0, 0, 0);
    send_char("R8 line bit4 ignored", 8'h96, 5'd16, 0, 0, 0);
    send_char("R9 reverse glyph",   8'h6B, 5'd1,  0, 0, 1);
    send_char("R9 reverse cursor",  8'h6B, 5'd1,  0, 1, 1);
    send_char("R9 reverse blank",   8'h6B, 5'd1,  1, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule